// File: doc/BRIEF.md
# Display Link Training Sequencer

This block runs the two-phase bring-up of a serial display link. It works against a sink through an abstract register port. Each access on that port carries a direction, a register address, a byte count and a six-byte data buffer. The sink answers with an acknowledge and the number of bytes it actually moved. A single `start` pulse launches the whole sequence:

- configuration writes;
- a clock-recovery phase that adjusts drive levels until every active lane locks;
- a channel-equalization phase with a bounded number of attempts;
- a closing write that turns the training pattern off.

Drive levels are a single byte that is applied to every lane. Each new value is the per-field maximum of the adjust requests from the active lanes, clamped to configured limits and flagged when a limit is hit.

The outcome is a one-cycle `done` pulse, with `pass` holding the result. On failure the block also gives a one-cycle `fallback` pulse, so that surrounding logic can retry at a lower rate or a narrower width. The delay before each status read is a cycle count taken from an input, with one value for each phase.

Top module: `lnk_train_seq`

## Requirements
- R1: Training opens with a 2-byte write to address 0x100: byte 0 is `bw_code`, byte 1 is `lane_cnt` with bit 7 set when `sink_enh` is 1. A 1-byte write of `rate_sel` to 0x115 follows only when `bw_code` is zero.
- R2: Next comes a 2-byte write to 0x107: byte 0 is 0x00 and byte 1 is 0x01 (8b/10b coding).
- R3: Clock recovery clears the drive byte to zero. It then writes to 0x102 with length `lane_cnt`+1: byte 0 is 0x21 (pattern 1, scrambling off) and bytes 1..`lane_cnt` hold the drive byte.
- R4: Lane status bytes come back in a 6-byte read from 0x202 (byte k in `acc_rdata[8k+7:8k]`). Lane i owns nibble bits [4i+3:4i] of bytes 0..1, whose bit 0 is clock-recovered. When every active lane (i < `lane_cnt`) has bit 0 set, clock recovery passes at once and equalization begins.
- R5: The adjust field for lane i sits at bits [4i+3:4i] of bytes 4..5: [1:0] is voltage and [3:2] is pre-emphasis. The new drive byte has voltage in [1:0], a swing-limit flag in bit 2, pre-emphasis in [4:3] and an emphasis-limit flag in bit 5. Each field is the maximum over active lanes only, clamped to `volt_lim`/`pre_lim` with its flag set when the maximum reaches the limit. The byte is written to 0x103 with length `lane_cnt`.
- R6: A repeat counter starts at 1. Each adjustment increments it when the new voltage equals the old voltage and otherwise sets it to 1. A failed status read with the counter at 5 ends training as a failure.
- R7: A failed status read that follows an adjustment whose result carried the swing-limit flag ends training as a failure, unless the lanes passed.
- R8: Equalization writes to 0x102 with byte 0 set to 0x23 when both `src_tps3` and `sink_tps3` are 1, and 0x22 otherwise, followed by the drive bytes as in R3.
- R9: Each equalization read fails if any active lane has lost bit 0. It passes if every active lane has nibble bits [2:0] all set and byte 2 bit 0 is set. Otherwise the drive is adjusted; after the fifth adjustment equalization gives up.
- R10: After equalization, whether it passed or failed, a 1-byte write of 0x00 to 0x102 turns the pattern off. Clock-recovery failures skip this write.
- R11: An acknowledge whose `acc_cnt` differs from `acc_len` ends training at once as a failure, with no further accesses.
- R12: A status read is issued no earlier than `cr_wait` (clock recovery) or `eq_wait` (equalization) cycles after the preceding write is acknowledged.
- R13: Completion gives a one-cycle `done`, with `pass` showing the result. A failure also gives a one-cycle `fallback`. A pending request keeps its fields stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin training (accepted when idle) |
| bw_code | input | 8 | Bandwidth code; zero selects rate-select write |
| rate_sel | input | 8 | Rate-select byte |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| sink_enh | input | 1 | Sink supports enhanced framing |
| src_tps3 | input | 1 | Source supports pattern 3 |
| sink_tps3 | input | 1 | Sink supports pattern 3 |
| volt_lim | input | 2 | Voltage swing limit |
| pre_lim | input | 2 | Pre-emphasis limit |
| cr_wait | input | DLY_W | Cycles before a clock-recovery status read |
| eq_wait | input | DLY_W | Cycles before an equalization status read |
| acc_req | output | 1 | Access request, held until acknowledged |
| acc_we | output | 1 | 1 write, 0 read |
| acc_addr | output | ADDR_W | Register address |
| acc_len | output | 3 | Byte count |
| acc_wdata | output | 48 | Write bytes, byte k at bits [8k+7:8k] |
| acc_ack | input | 1 | Access complete |
| acc_cnt | input | 3 | Bytes actually transferred |
| acc_rdata | input | 48 | Read bytes |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last training |
| fallback | output | 1 | One-cycle failure pulse |

## Verification
The hardest situations to reach are the two clock-recovery exits, because each depends on the history of several reads. The repeat exit needs four consecutive adjustments that leave voltage unchanged. The swing exit needs an adjustment that lands on the limit, followed by one more failed read. The bench's sink model answers status reads from a per-scenario script: a number of reads that report no lock, fixed adjust bytes, and optional loss of lock during equalization. Those scripts steer the sequencer into each exit, and adjust values on inactive lanes are set to the maximum to show they are ignored.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_RATE, S_SPRD, S_CRSET, S_CRWT, S_CRRD, S_CREV,
    S_CRUPD, S_EQSET, S_EQWT, S_EQRD, S_EQEV, S_EQUPD, S_OFF, S_END
  } seq_st_e;

  localparam int NLANE = 4;
  localparam logic [11:0] A_BW   = 12'h100;
  localparam logic [11:0] A_PAT  = 12'h102;
  localparam logic [11:0] A_LANE = 12'h103;
  localparam logic [11:0] A_SPRD = 12'h107;
  localparam logic [11:0] A_RATE = 12'h115;
  localparam logic [11:0] A_STAT = 12'h202;
  localparam logic [7:0] PAT_CR  = 8'h21;
  localparam logic [7:0] PAT_EQ2 = 8'h22;
  localparam logic [7:0] PAT_EQ3 = 8'h23;
  localparam logic [7:0] PAT_OFF = 8'h00;
  localparam logic [7:0] CODE_8B10B = 8'h01;

  function automatic logic is_acc(input seq_st_e s);
    return s inside {S_CFG, S_RATE, S_SPRD, S_CRSET, S_CRRD, S_CRUPD,
                     S_EQSET, S_EQRD, S_EQUPD, S_OFF};
  endfunction
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lt_lane_check.sv
module lt_lane_check #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   act,
  input  logic [4*LANES-1:0] lane_st,
  input  logic               aligned,
  output logic               cr_all,
  output logic               eq_all
);
  logic [LANES-1:0] cr_ok, eq_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic spare_unused;
    assign spare_unused = lane_st[4*i+3];
    assign cr_ok[i] = !act[i] || lane_st[4*i];
    assign eq_ok[i] = !act[i] || (&lane_st[4*i +: 3]);
  end

  assign cr_all = &cr_ok;
  assign eq_all = (&eq_ok) && aligned;
endmodule

// File: rtl/lt_drive_merge.sv
module lt_drive_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   act,
  input  logic [4*LANES-1:0] adj,
  input  logic [1:0]         v_lim,
  input  logic [1:0]         p_lim,
  output logic [7:0]         drive
);
  logic [1:0] v_run [LANES+1];
  logic [1:0] p_run [LANES+1];
  logic       v_hit, p_hit;

  assign v_run[0] = 2'd0;
  assign p_run[0] = 2'd0;

  for (genvar i = 0; i < LANES; i++) begin : g_max
    logic [1:0] v_i, p_i;
    assign v_i = adj[4*i +: 2];
    assign p_i = adj[4*i+2 +: 2];
    assign v_run[i+1] = (act[i] && (v_i > v_run[i])) ? v_i : v_run[i];
    assign p_run[i+1] = (act[i] && (p_i > p_run[i])) ? p_i : p_run[i];
  end

  always_comb begin
    v_hit      = (v_run[LANES] >= v_lim);
    p_hit      = (p_run[LANES] >= p_lim);
    drive      = 8'h00;
    drive[1:0] = v_hit ? v_lim : v_run[LANES];
    drive[2]   = v_hit;
    drive[4:3] = p_hit ? p_lim : p_run[LANES];
    drive[5]   = p_hit;
  end
endmodule

// File: rtl/lnk_train_seq.sv
module lnk_train_seq
  import lt_pkg::*;
#(
  parameter int DLY_W      = 16,
  parameter int ADDR_W     = 12,
  parameter int VOLT_TRIES = 5,
  parameter int EQ_TRIES   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        bw_code,
  input  logic [7:0]        rate_sel,
  input  logic [2:0]        lane_cnt,
  input  logic              sink_enh,
  input  logic              src_tps3,
  input  logic              sink_tps3,
  input  logic [1:0]        volt_lim,
  input  logic [1:0]        pre_lim,
  input  logic [DLY_W-1:0]  cr_wait,
  input  logic [DLY_W-1:0]  eq_wait,
  output logic              acc_req,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [2:0]        acc_len,
  output logic [47:0]       acc_wdata,
  input  logic              acc_ack,
  input  logic [2:0]        acc_cnt,
  input  logic [47:0]       acc_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fallback
);
  localparam int VT_W = $clog2(VOLT_TRIES + 1);
  localparam int EQ_W = $clog2(EQ_TRIES + 1);

  seq_st_e     st, st_n;
  logic [7:0]  drv, drv_n, drv_new, eq_pat;
  logic [VT_W-1:0] vtries;
  logic [EQ_W-1:0] eq_n;
  logic        maxsw, res_ok, res_n;
  logic [47:0] stat;
  logic [NLANE-1:0] act;
  logic        cr_all, eq_all, tmr_load, tmr_done;
  logic        acc_done, acc_bad, launch;
  logic        rq_we;
  logic [11:0] rq_addr;
  logic [2:0]  rq_len;
  logic [47:0] rq_wd;
  logic        stat_unused;

  assign stat_unused = ^stat[31:17];

  for (genvar i = 0; i < NLANE; i++) begin : g_act
    assign act[i] = (3'(i) < lane_cnt);
  end

  assign eq_pat = (src_tps3 && sink_tps3) ? PAT_EQ3 : PAT_EQ2;

  lt_lane_check #(.LANES(NLANE)) i_check (
    .act(act), .lane_st(stat[15:0]), .aligned(stat[16]),
    .cr_all(cr_all), .eq_all(eq_all));

  lt_drive_merge #(.LANES(NLANE)) i_merge (
    .act(act), .adj(stat[47:32]), .v_lim(volt_lim), .p_lim(pre_lim),
    .drive(drv_new));

  assign tmr_load = acc_done && (st inside {S_CRSET, S_CRUPD, S_EQSET, S_EQUPD});

  lt_wait_timer #(.W(DLY_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load),
    .val((st == S_CRSET || st == S_CRUPD) ? cr_wait : eq_wait),
    .expired(tmr_done));

  // Sequencing
  always_comb begin
    st_n     = st;
    res_n    = res_ok;
    drv_n    = drv;
    acc_done = acc_req && acc_ack;
    acc_bad  = acc_done && (acc_cnt != acc_len);
    unique case (st)
      S_IDLE:  if (start) begin st_n = S_CFG; res_n = 1'b0; end
      S_CFG:   if (acc_done) st_n = (bw_code == 8'h00) ? S_RATE : S_SPRD;
      S_RATE:  if (acc_done) st_n = S_SPRD;
      S_SPRD:  if (acc_done) begin st_n = S_CRSET; drv_n = 8'h00; end
      S_CRSET: if (acc_done) st_n = S_CRWT;
      S_CRWT:  if (tmr_done) st_n = S_CRRD;
      S_CRRD:  if (acc_done) st_n = S_CREV;
      S_CREV: begin
        if (cr_all)                                    st_n = S_EQSET;
        else if (vtries == VT_W'(VOLT_TRIES) || maxsw) st_n = S_END;
        else begin st_n = S_CRUPD; drv_n = drv_new; end
      end
      S_CRUPD: if (acc_done) st_n = S_CRWT;
      S_EQSET: if (acc_done) st_n = S_EQWT;
      S_EQWT:  if (tmr_done) st_n = S_EQRD;
      S_EQRD:  if (acc_done) st_n = S_EQEV;
      S_EQEV: begin
        if (!cr_all)     st_n = S_OFF;
        else if (eq_all) begin st_n = S_OFF; res_n = 1'b1; end
        else begin st_n = S_EQUPD; drv_n = drv_new; end
      end
      S_EQUPD: if (acc_done) st_n = (eq_n == EQ_W'(EQ_TRIES)) ? S_OFF : S_EQWT;
      S_OFF:   if (acc_done) st_n = S_END;
      S_END:   st_n = S_IDLE;
    endcase
    if (acc_bad) begin st_n = S_END; res_n = 1'b0; end
  end

  // Request builder for the state being entered
  always_comb begin
    rq_we   = 1'b1;
    rq_addr = A_PAT;
    rq_len  = 3'd0;
    rq_wd   = '0;
    unique case (st_n)
      S_CFG:   begin rq_addr = A_BW; rq_len = 3'd2;
                     rq_wd = {32'h0, sink_enh, 4'b0000, lane_cnt, bw_code}; end
      S_RATE:  begin rq_addr = A_RATE; rq_len = 3'd1; rq_wd = {40'h0, rate_sel}; end
      S_SPRD:  begin rq_addr = A_SPRD; rq_len = 3'd2; rq_wd = {32'h0, CODE_8B10B, 8'h00}; end
      S_CRSET: begin rq_len = lane_cnt + 3'd1; rq_wd = {8'h00, {NLANE{drv_n}}, PAT_CR}; end
      S_EQSET: begin rq_len = lane_cnt + 3'd1; rq_wd = {8'h00, {NLANE{drv_n}}, eq_pat}; end
      S_CRUPD, S_EQUPD: begin rq_addr = A_LANE; rq_len = lane_cnt;
                              rq_wd = {16'h0, {NLANE{drv_n}}}; end
      S_CRRD, S_EQRD: begin rq_we = 1'b0; rq_addr = A_STAT; rq_len = 3'd6; end
      S_OFF:   begin rq_len = 3'd1; rq_wd = {40'h0, PAT_OFF}; end
      default: ;
    endcase
  end

  assign launch = (st_n != st) && is_acc(st_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; drv <= 8'h00; res_ok <= 1'b0; vtries <= '0; maxsw <= 1'b0;
      eq_n <= '0; stat <= '0; acc_req <= 1'b0; acc_we <= 1'b0; acc_addr <= '0;
      acc_len <= '0; acc_wdata <= '0; busy <= 1'b0; done <= 1'b0; pass <= 1'b0;
      fallback <= 1'b0;
    end else begin
      st     <= st_n;
      drv    <= drv_n;
      res_ok <= res_n;
      if (acc_done) acc_req <= 1'b0;
      if (launch) begin
        acc_req <= 1'b1; acc_we <= rq_we; acc_addr <= ADDR_W'(rq_addr);
        acc_len <= rq_len; acc_wdata <= rq_wd;
      end
      if (acc_done && !acc_we) stat <= acc_rdata;
      if (st == S_IDLE && start) begin
        vtries <= VT_W'(1); maxsw <= 1'b0; eq_n <= '0; pass <= 1'b0;
      end
      if (st == S_CREV && st_n == S_CRUPD) begin
        vtries <= (drv_new[1:0] == drv[1:0]) ? vtries + 1'b1 : VT_W'(1);
        maxsw  <= drv_new[2];
      end
      if (st == S_EQEV && st_n == S_EQUPD) eq_n <= eq_n + 1'b1;
      done     <= (st == S_END);
      fallback <= (st == S_END) && !res_ok;
      if (st == S_END) pass <= res_ok;
      busy     <= (st_n != S_IDLE);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_wdata) && $stable(acc_len)); // R13
  AST_FB_PULSE: assert property (@(posedge clk) disable iff (rst)
    fallback |=> !fallback); // R13
  AST_DONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fallback)); // R13
  AST_OFF_LEN: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_we && acc_addr == ADDR_W'(A_PAT) && acc_wdata[1:0] == 2'd0 |-> acc_len == 3'd1); // R10
  AST_SET_LEN: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_we && acc_addr == ADDR_W'(A_PAT) && acc_wdata[1:0] != 2'd0
    |-> acc_len == lane_cnt + 3'd1); // R3
  AST_DRV_LIMIT: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_addr == ADDR_W'(A_LANE)
    |-> acc_wdata[1:0] <= volt_lim && acc_wdata[4:3] <= pre_lim); // R5
endmodule

// File: tb/test_lnk_train_seq.sv
`timescale 1ns/1ps
module test_lnk_train_seq;
  typedef struct packed {
    logic [2:0]  lanes;
    logic [7:0]  bw;
    logic        enh, s3, k3;
    logic [1:0]  vl, pl;
    logic [15:0] adj;
    logic [7:0]  crf, eqf;
    logic        crl, xpass;
    logic [7:0]  xwr, xrd, xupd, xdrv, xpat;
  } row_t;

  localparam row_t TBL [7] = '{
    '{3'd4, 8'h0A, 1'b1, 1'b1, 1'b1, 2'd3, 2'd3, 16'h0000, 8'd0,  8'd0,  1'b0, 1'b1, 8'd5,  8'd2, 8'd0, 8'h00, 8'h23},
    '{3'd2, 8'h14, 1'b0, 1'b1, 1'b0, 2'd3, 2'd3, 16'hFF29, 8'd1,  8'd0,  1'b0, 1'b1, 8'd6,  8'd3, 8'd1, 8'h12, 8'h22},
    '{3'd1, 8'h06, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 16'h0000, 8'd99, 8'd0,  1'b0, 1'b0, 8'd7,  8'd5, 8'd4, 8'h00, 8'h00},
    '{3'd4, 8'h0A, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3, 16'h3333, 8'd99, 8'd0,  1'b0, 1'b0, 8'd4,  8'd2, 8'd1, 8'h07, 8'h00},
    '{3'd2, 8'h00, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 16'hFF07, 8'd1,  8'd2,  1'b0, 1'b1, 8'd9,  8'd5, 8'd3, 8'h2E, 8'h22},
    '{3'd4, 8'h0A, 1'b0, 1'b1, 1'b1, 2'd3, 2'd3, 16'h0000, 8'd0,  8'd99, 1'b0, 1'b0, 8'd10, 8'd6, 8'd5, 8'h00, 8'h23},
    '{3'd1, 8'h0A, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 16'h0000, 8'd0,  8'd0,  1'b1, 1'b0, 8'd5,  8'd2, 8'd0, 8'h00, 8'h22}
  };
  localparam int CRW = 6;
  localparam int EQW = 9;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] bw_code = '0, rate_sel = 8'h5A;
  logic [2:0] lane_cnt = 3'd1;
  logic sink_enh = 0, src_tps3 = 0, sink_tps3 = 0;
  logic [1:0] volt_lim = 2'd3, pre_lim = 2'd3;
  logic [15:0] cr_wait = 16'(CRW), eq_wait = 16'(EQW);
  logic acc_req, acc_we, acc_ack = 1'b0;
  logic [11:0] acc_addr;
  logic [2:0] acc_len, acc_cnt = '0;
  logic [47:0] acc_wdata, acc_rdata = '0;
  logic busy, done, pass, fallback;

  always #2 clk = ~clk;

  lnk_train_seq i_lnk_train_seq (
    .clk(clk), .rst(rst), .start(start), .bw_code(bw_code), .rate_sel(rate_sel),
    .lane_cnt(lane_cnt), .sink_enh(sink_enh), .src_tps3(src_tps3), .sink_tps3(sink_tps3),
    .volt_lim(volt_lim), .pre_lim(pre_lim), .cr_wait(cr_wait), .eq_wait(eq_wait),
    .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_cnt(acc_cnt), .acc_rdata(acc_rdata),
    .busy(busy), .done(done), .pass(pass), .fallback(fallback));

  int n_chk = 0, n_bad = 0, cyc = 0;
  row_t cur;
  int err_idx = -1, acc_idx, wr_cnt, rd_cnt, upd_cnt, rate_cnt, dis_cnt, cr_rd, eq_rd;
  int fb_cnt, done_cnt, last_wr_cyc;
  bit cfg_ok, sprd_ok, crset_ok, dis_ok, gap_ok, in_eq;
  logic [7:0] last_drv, eq_pat_seen;

  always @(posedge clk) cyc++;

  // Sink model and access monitor, acting on falling edges
  always @(negedge clk) begin
    if (fallback) fb_cnt++;
    if (done) done_cnt++;
    if (rst) acc_ack = 1'b0;
    else if (acc_ack) acc_ack = 1'b0;
    else if (acc_req) begin
      acc_ack = 1'b1;
      acc_cnt = (acc_idx == err_idx) ? acc_len - 3'd1 : acc_len;
      acc_idx++;
      if (acc_we) begin
        wr_cnt++;
        last_wr_cyc = cyc;
        case (acc_addr)
          12'h100: cfg_ok = (acc_len == 3'd2) && (acc_wdata[7:0] == cur.bw) &&
                            (acc_wdata[15:8] == {cur.enh, 4'b0, cur.lanes});
          12'h115: begin rate_cnt++; if (acc_wdata[7:0] != rate_sel) cfg_ok = 0; end
          12'h107: sprd_ok = (acc_len == 3'd2) && (acc_wdata[15:0] == 16'h0100);
          12'h102: begin
            if (acc_wdata[7:0] == 8'h00) begin
              dis_cnt++; if (acc_len != 3'd1) dis_ok = 0;
            end else begin
              if (acc_wdata[7:0] == 8'h21) begin
                crset_ok = (acc_len == cur.lanes + 3'd1);
                for (int k = 1; k <= int'(cur.lanes); k++)
                  if (acc_wdata[8*k +: 8] != 8'h00) crset_ok = 0;
              end else begin
                in_eq = 1; eq_pat_seen = acc_wdata[7:0];
              end
            end
          end
          12'h103: begin upd_cnt++; last_drv = acc_wdata[7:0]; end
          default: ;
        endcase
      end else begin
        rd_cnt++;
        if ((cyc - last_wr_cyc) < (in_eq ? EQW : CRW)) gap_ok = 0;
        if (!in_eq) begin
          acc_rdata = {cur.adj, 8'h00, 8'h00, (cr_rd >= int'(cur.crf)) ? 16'h1111 : 16'h0000};
          cr_rd++;
        end else begin
          if (cur.crl && eq_rd == 0) acc_rdata = {cur.adj, 16'h0000, 16'h0000};
          else if (eq_rd >= int'(cur.eqf)) acc_rdata = {cur.adj, 8'h00, 8'h01, 16'h7777};
          else acc_rdata = {cur.adj, 8'h00, 8'h00, 16'h1111};
          eq_rd++;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run(input row_t r, input int err_at);
    @(posedge clk); #1;
    cur = r; err_idx = err_at; acc_idx = 0; wr_cnt = 0; rd_cnt = 0; upd_cnt = 0;
    rate_cnt = 0; dis_cnt = 0; cr_rd = 0; eq_rd = 0; fb_cnt = 0; done_cnt = 0;
    cfg_ok = 0; sprd_ok = 0; crset_ok = 0; dis_ok = 1; gap_ok = 1; in_eq = 0;
    last_drv = 8'h00; eq_pat_seen = 8'h00; last_wr_cyc = cyc;
    lane_cnt = r.lanes; bw_code = r.bw; sink_enh = r.enh; src_tps3 = r.s3;
    sink_tps3 = r.k3; volt_lim = r.vl; pre_lim = r.pl; start = 1;
    @(posedge clk); #1; start = 0;
    for (int t = 0; t < 5000 && done_cnt == 0; t++) begin @(posedge clk); #1; end
    repeat (3) begin @(posedge clk); #1; end
    chk("R13 done pulse count", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    rst = 0;
    @(posedge clk); #1;
    chk("R13 reset busy/done/pass/fallback/req", {busy, done, pass, fallback, acc_req}, 0);

    for (int i = 0; i < 7; i++) begin
      run(TBL[i], -1);
      chk("R4 R9 R13 pass result", pass, TBL[i].xpass);
      chk("R13 fallback pulses", fb_cnt, TBL[i].xpass ? 0 : 1);
      chk("R1 config write", cfg_ok, 1);
      chk("R1 rate-select writes", rate_cnt, (TBL[i].bw == 8'h00) ? 1 : 0);
      chk("R2 spread/coding write", sprd_ok, 1);
      chk("R3 clock-recovery start write", crset_ok, 1);
      chk("R4 R6 R7 R9 write count", wr_cnt, TBL[i].xwr);
      chk("R4 R6 R7 R9 read count", rd_cnt, TBL[i].xrd);
      chk("R5 adjust write count", upd_cnt, TBL[i].xupd);
      chk("R5 last drive byte", last_drv, TBL[i].xdrv);
      chk("R8 equalization pattern", eq_pat_seen, TBL[i].xpat);
      chk("R10 pattern-off writes", dis_cnt, (TBL[i].xpat != 8'h00) ? 1 : 0);
      chk("R10 pattern-off length", dis_ok, 1);
      chk("R12 read delay", gap_ok, 1);
    end

    // R11: short write on access 1 (spread), then short read on access 3
    run(TBL[0], 1);
    chk("R11 short write result", pass, 0);
    chk("R11 short write fallback", fb_cnt, 1);
    chk("R11 short write accesses", acc_idx, 2);
    run(TBL[0], 3);
    chk("R11 short read result", pass, 0);
    chk("R11 short read fallback", fb_cnt, 1);
    chk("R11 short read accesses", acc_idx, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule